// File: doc/BRIEF.md
# Multi-Channel Thermal Threshold Interrupt Controller

This block watches a set of temperature channels, each fed by a sampling sequencer through a write port. Every channel holds its latest committed temperature and three signed thresholds: upper, lower and critical. Each channel compares its temperature with all three thresholds and keeps a separate status bit per class. Per-channel mask and clear fields, together with a three-bit global enable, decide which violations reach two level-sensitive outputs. One output carries the upper and lower violations. The other carries critical violations and the sequencer health events.

A sequencer watchdog raises a sticky bark when no sampling cycle completes within a programmable number of clock cycles. It counts these expiries in a saturating counter. A cycle-completion monitor flags each completed cycle unless it is masked. All values are signed two's complement in tenths of a degree. Software reaches everything through a word-addressed read/write port with a combinational read.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: After reset, all status bits, both interrupts, the bark flag and the bark count read 0. All valid bits read 1. The enable field reads 0. Every mask bit reads 1. The timeout reads 0.
- R2: Bit i of the upper status word (address 0x0A) is 1 while channel i's committed temperature is greater than or equal to its upper threshold. Thresholds sit at 0x10+4*i (+0 upper, +1 lower, +2 critical, +3 committed temperature, read sign-extended). The comparison is signed and inclusive.
- R3: Bit i of the lower status word (0x0B) is 1 while the committed temperature is less than or equal to the lower threshold, using a signed comparison.
- R4: Bit i of the critical status word (0x0C) is 1 while the committed temperature is greater than or equal to the critical threshold. This bit is independent of the upper and lower bits.
- R5: A sample write clears bit i of the valid word (0x0D) for exactly 6 cycles. The previous temperature stays visible until valid returns to 1, and the new value shows at that moment.
- R6: A violation reaches an interrupt only when its mask bit is 0. The masks sit at 0x04 (upper), 0x05 (lower) and 0x06 (critical), one bit per channel.
- R7: The enable field at 0x00 has bit 0 for upper, bit 1 for lower and bit 2 for the critical output (including the watchdog sources). A value of 0 holds both outputs low.
- R8: While a clear bit is 1 (0x07 upper, 0x08 lower, 0x09 critical), the matching status bit reads 0. After the clear bit is written back to 0, the status bit follows the comparison again.
- R9: Interrupts are level-sensitive. Once the temperature returns inside its limits, status and interrupt drop without any software write.
- R10: With a nonzero timeout T (0x02), bark (bit 0 of 0x03) sets T cycles after the last cycle completion. A timeout of 0 stops the watchdog. Bark stays set until the bark clear (bit 0 of 0x01) is written 1 and then 0.
- R11: The bark count (bits 15:8 of 0x03) increments on each expiry and saturates at 255.
- R12: Bark drives the critical interrupt when the bark mask (bit 1 of 0x01) is 0.
- R13: When the monitor mask (bit 3 of 0x01) is 0, a cycle completion sets the monitor flag (bit 1 of 0x03). That flag drives the critical interrupt. The monitor clear (bit 2 of 0x01) works with the same write 1 then 0 sequence. With the mask at 1, completions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_we_i | input | 1 | Sample write strobe from the sequencer |
| smp_ch_i | input | 2 | Channel of the sample |
| smp_temp_i | input | 12 | Sampled temperature, signed, 0.1 degree units |
| cycle_done_i | input | 1 | Sequencer finished a full sampling cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_uplow_o | output | 1 | Upper/lower violation interrupt, level |
| irq_crit_o | output | 1 | Critical and watchdog interrupt, level |

## Verification
The hardest condition to reach is the saturated bark counter. It needs 255 separate watchdog expiries. The bench gets there by setting the timeout to one cycle and holding off cycle completions for a few hundred cycles. It then checks that the count stays pinned at 255. The exact 6-cycle valid window is also hard to observe. The bench reads the valid word and the temperature register one negative edge before and one after the commit edge. The inclusive threshold edges are covered by samples equal to and one step past each threshold, including negative values.

// File: rtl/thermal_irq_pkg.sv
package thermal_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_WDOG  = 8'h01;
  localparam logic [ADDR_W-1:0] A_TMO   = 8'h02;
  localparam logic [ADDR_W-1:0] A_WST   = 8'h03;
  localparam logic [ADDR_W-1:0] A_UPM   = 8'h04;
  localparam logic [ADDR_W-1:0] A_LOM   = 8'h05;
  localparam logic [ADDR_W-1:0] A_CRM   = 8'h06;
  localparam logic [ADDR_W-1:0] A_UPC   = 8'h07;
  localparam logic [ADDR_W-1:0] A_LOC   = 8'h08;
  localparam logic [ADDR_W-1:0] A_CRC   = 8'h09;
  localparam logic [ADDR_W-1:0] A_UPS   = 8'h0A;
  localparam logic [ADDR_W-1:0] A_LOS   = 8'h0B;
  localparam logic [ADDR_W-1:0] A_CRS   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_VAL   = 8'h0D;
  localparam logic [ADDR_W-1:0] CH_BASE = 8'h10;

  typedef enum logic [1:0] {
    F_UP   = 2'd0,
    F_LO   = 2'd1,
    F_CR   = 2'd2,
    F_TEMP = 2'd3
  } chan_field_e;

  typedef struct packed {
    logic up;
    logic lo;
    logic cr;
  } viol_t;
endpackage

// File: rtl/thermal_chan.sv
module thermal_chan
  import thermal_irq_pkg::*;
#(
  parameter int unsigned TEMP_W     = 12,
  parameter int unsigned VALID_HOLD = 6,
  localparam int unsigned HOLD_W    = $clog2(VALID_HOLD + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_we_i,
  input  logic signed [TEMP_W-1:0] smp_temp_i,
  input  logic [2:0]               thr_we_i,    // {crit, lower, upper}
  input  logic signed [TEMP_W-1:0] thr_wdata_i,
  input  viol_t                    clr_i,
  output logic signed [TEMP_W-1:0] temp_o,
  output logic                     valid_o,
  output logic signed [TEMP_W-1:0] thr_up_o,
  output logic signed [TEMP_W-1:0] thr_lo_o,
  output logic signed [TEMP_W-1:0] thr_cr_o,
  output viol_t                    stat_o
);
  localparam logic signed [TEMP_W-1:0] T_MAX = {1'b0, {(TEMP_W-1){1'b1}}};
  localparam logic signed [TEMP_W-1:0] T_MIN = {1'b1, {(TEMP_W-1){1'b0}}};

  logic [HOLD_W-1:0]        hold_q;
  logic signed [TEMP_W-1:0] stage_q, temp_q;
  logic signed [TEMP_W-1:0] up_q, lo_q, cr_q;
  viol_t                    stat_q;

  // sample staging: new value committed when the hold window ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      stage_q <= '0;
      temp_q  <= '0;
    end else if (smp_we_i) begin
      stage_q <= smp_temp_i;
      hold_q  <= HOLD_W'(VALID_HOLD);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
      if (hold_q == HOLD_W'(1)) temp_q <= stage_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= T_MAX;
      lo_q <= T_MIN;
      cr_q <= T_MAX;
    end else begin
      if (thr_we_i[0]) up_q <= thr_wdata_i;
      if (thr_we_i[1]) lo_q <= thr_wdata_i;
      if (thr_we_i[2]) cr_q <= thr_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else begin
      stat_q.up <= (temp_q >= up_q) & ~clr_i.up;
      stat_q.lo <= (temp_q <= lo_q) & ~clr_i.lo;
      stat_q.cr <= (temp_q >= cr_q) & ~clr_i.cr;
    end
  end

  assign temp_o   = temp_q;
  assign valid_o  = (hold_q == '0);
  assign thr_up_o = up_q;
  assign thr_lo_o = lo_q;
  assign thr_cr_o = cr_q;
  assign stat_o   = stat_q;

  p_valid_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_we_i |=> !valid_o);
  p_temp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !smp_we_i) |=> (valid_o || $stable(temp_o)));
  p_clr_up_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i.up |=> !stat_o.up);
  p_clr_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i.lo |=> !stat_o.lo);
  p_clr_cr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i.cr |=> !stat_o.cr);
endmodule

// File: rtl/thermal_wdog.sv
module thermal_wdog #(
  parameter int unsigned TMO_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cycle_done_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             bark_clr_i,
  input  logic             cc_mask_i,
  input  logic             cc_clr_i,
  output logic             bark_o,
  output logic [CNT_W-1:0] bark_cnt_o,
  output logic             cc_evt_o
);
  logic [TMO_W-1:0] timer_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bark_q, cc_q, wd_on, fire;

  assign wd_on = (timeout_i != '0);
  assign fire  = wd_on && !cycle_done_i && (timer_q >= timeout_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      cnt_q   <= '0;
      bark_q  <= 1'b0;
      cc_q    <= 1'b0;
    end else begin
      if (cycle_done_i || !wd_on || fire) timer_q <= '0;
      else                                timer_q <= timer_q + 1'b1;
      if (fire && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
      bark_q <= bark_clr_i ? 1'b0 : (bark_q | fire);
      cc_q   <= cc_clr_i ? 1'b0 : (cc_q | (cycle_done_i & ~cc_mask_i));
    end
  end

  assign bark_o     = bark_q;
  assign bark_cnt_o = cnt_q;
  assign cc_evt_o   = cc_q;

  p_cnt_sat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q) |=> (&cnt_q));
  p_cnt_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bark_o |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  p_bark_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bark_clr_i |=> !bark_o);
  p_bark_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bark_o && !bark_clr_i) |=> bark_o);
  p_wd_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i == '0 && !bark_o) |=> !bark_o);
  p_cc_mask_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_mask_i && !cc_evt_o) |=> !cc_evt_o);
endmodule

// File: rtl/thermal_irq_ctrl.sv
module thermal_irq_ctrl
  import thermal_irq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned TEMP_W     = 12,
  parameter int unsigned VALID_HOLD = 6,
  parameter int unsigned TMO_W      = 16,
  parameter int unsigned CNT_W      = 8,
  localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_we_i,
  input  logic [CH_W-1:0]          smp_ch_i,
  input  logic signed [TEMP_W-1:0] smp_temp_i,
  input  logic                     cycle_done_i,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic                     irq_uplow_o,
  output logic                     irq_crit_o
);
  localparam int unsigned SEL_W = ADDR_W - 2;

  logic [2:0]        int_en_q;
  logic              bark_clr_q, bark_mask_q, cc_clr_q, cc_mask_q;
  logic [TMO_W-1:0]  timeout_q;
  logic [NUM_CH-1:0] up_mask_q, lo_mask_q, cr_mask_q;
  logic [NUM_CH-1:0] up_clr_q, lo_clr_q, cr_clr_q;
  logic [NUM_CH-1:0] up_stat, lo_stat, cr_stat, valid_v;

  logic signed [TEMP_W-1:0] temp_a [NUM_CH];
  logic signed [TEMP_W-1:0] up_a   [NUM_CH];
  logic signed [TEMP_W-1:0] lo_a   [NUM_CH];
  logic signed [TEMP_W-1:0] cr_a   [NUM_CH];

  logic [ADDR_W-1:0] rel;
  logic [SEL_W-1:0]  ch_sel;
  logic [CH_W-1:0]   ch_idx;
  logic [1:0]        fld;
  logic              ch_hit;

  assign rel    = reg_addr_i - CH_BASE;
  assign ch_sel = rel[ADDR_W-1:2];
  assign fld    = rel[1:0];
  assign ch_idx = ch_sel[CH_W-1:0];
  assign ch_hit = (reg_addr_i >= CH_BASE) && (ch_sel < SEL_W'(NUM_CH));

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q    <= '0;
      bark_clr_q  <= 1'b0;
      bark_mask_q <= 1'b1;
      cc_clr_q    <= 1'b0;
      cc_mask_q   <= 1'b1;
      timeout_q   <= '0;
      up_mask_q   <= '1;
      lo_mask_q   <= '1;
      cr_mask_q   <= '1;
      up_clr_q    <= '0;
      lo_clr_q    <= '0;
      cr_clr_q    <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL: int_en_q <= reg_wdata_i[2:0];
        A_WDOG: {cc_mask_q, cc_clr_q, bark_mask_q, bark_clr_q} <= reg_wdata_i[3:0];
        A_TMO:  timeout_q <= reg_wdata_i[TMO_W-1:0];
        A_UPM:  up_mask_q <= reg_wdata_i[NUM_CH-1:0];
        A_LOM:  lo_mask_q <= reg_wdata_i[NUM_CH-1:0];
        A_CRM:  cr_mask_q <= reg_wdata_i[NUM_CH-1:0];
        A_UPC:  up_clr_q  <= reg_wdata_i[NUM_CH-1:0];
        A_LOC:  lo_clr_q  <= reg_wdata_i[NUM_CH-1:0];
        A_CRC:  cr_clr_q  <= reg_wdata_i[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [2:0] thr_we;
    viol_t      clr_v, stat_v;
    logic       sel;

    assign sel       = reg_we_i && ch_hit && (ch_idx == CH_W'(i));
    assign thr_we[0] = sel && (fld == F_UP);
    assign thr_we[1] = sel && (fld == F_LO);
    assign thr_we[2] = sel && (fld == F_CR);
    assign clr_v.up  = up_clr_q[i];
    assign clr_v.lo  = lo_clr_q[i];
    assign clr_v.cr  = cr_clr_q[i];

    thermal_chan #(
      .TEMP_W     (TEMP_W),
      .VALID_HOLD (VALID_HOLD)
    ) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .smp_we_i    (smp_we_i && (smp_ch_i == CH_W'(i))),
      .smp_temp_i  (smp_temp_i),
      .thr_we_i    (thr_we),
      .thr_wdata_i (reg_wdata_i[TEMP_W-1:0]),
      .clr_i       (clr_v),
      .temp_o      (temp_a[i]),
      .valid_o     (valid_v[i]),
      .thr_up_o    (up_a[i]),
      .thr_lo_o    (lo_a[i]),
      .thr_cr_o    (cr_a[i]),
      .stat_o      (stat_v)
    );

    assign up_stat[i] = stat_v.up;
    assign lo_stat[i] = stat_v.lo;
    assign cr_stat[i] = stat_v.cr;
  end

  logic             bark, cc_evt;
  logic [CNT_W-1:0] bark_cnt;

  thermal_wdog #(
    .TMO_W (TMO_W),
    .CNT_W (CNT_W)
  ) u_wdog (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cycle_done_i (cycle_done_i),
    .timeout_i    (timeout_q),
    .bark_clr_i   (bark_clr_q),
    .cc_mask_i    (cc_mask_q),
    .cc_clr_i     (cc_clr_q),
    .bark_o       (bark),
    .bark_cnt_o   (bark_cnt),
    .cc_evt_o     (cc_evt)
  );

  function automatic logic [DATA_W-1:0] sext(input logic signed [TEMP_W-1:0] v);
    return {{(DATA_W-TEMP_W){v[TEMP_W-1]}}, v};
  endfunction

  always_comb begin
    reg_rdata_o = '0;
    if (ch_hit) begin
      case (fld)
        F_UP:    reg_rdata_o = sext(up_a[ch_idx]);
        F_LO:    reg_rdata_o = sext(lo_a[ch_idx]);
        F_CR:    reg_rdata_o = sext(cr_a[ch_idx]);
        default: reg_rdata_o = sext(temp_a[ch_idx]);
      endcase
    end else begin
      case (reg_addr_i)
        A_CTRL: reg_rdata_o[2:0] = int_en_q;
        A_WDOG: reg_rdata_o[3:0] = {cc_mask_q, cc_clr_q, bark_mask_q, bark_clr_q};
        A_TMO:  reg_rdata_o[TMO_W-1:0] = timeout_q;
        A_WST: begin
          reg_rdata_o[0]         = bark;
          reg_rdata_o[1]         = cc_evt;
          reg_rdata_o[8 +: CNT_W] = bark_cnt;
        end
        A_UPM:  reg_rdata_o[NUM_CH-1:0] = up_mask_q;
        A_LOM:  reg_rdata_o[NUM_CH-1:0] = lo_mask_q;
        A_CRM:  reg_rdata_o[NUM_CH-1:0] = cr_mask_q;
        A_UPC:  reg_rdata_o[NUM_CH-1:0] = up_clr_q;
        A_LOC:  reg_rdata_o[NUM_CH-1:0] = lo_clr_q;
        A_CRC:  reg_rdata_o[NUM_CH-1:0] = cr_clr_q;
        A_UPS:  reg_rdata_o[NUM_CH-1:0] = up_stat;
        A_LOS:  reg_rdata_o[NUM_CH-1:0] = lo_stat;
        A_CRS:  reg_rdata_o[NUM_CH-1:0] = cr_stat;
        A_VAL:  reg_rdata_o[NUM_CH-1:0] = valid_v;
        default: ;
      endcase
    end
  end

  logic up_src, lo_src, cr_src;
  assign up_src = |(up_stat & ~up_mask_q);
  assign lo_src = |(lo_stat & ~lo_mask_q);
  assign cr_src = |(cr_stat & ~cr_mask_q);

  assign irq_uplow_o = (int_en_q[0] & up_src) | (int_en_q[1] & lo_src);
  assign irq_crit_o  = int_en_q[2] &
                       (cr_src | (bark & ~bark_mask_q) | (cc_evt & ~cc_mask_q));

  logic unused_bits;
  assign unused_bits = ^{reg_wdata_i, ch_sel};

  p_irq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_q == 3'b000) |-> (!irq_uplow_o && !irq_crit_o));
  p_mask_uplow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&up_mask_q) && (&lo_mask_q)) |-> !irq_uplow_o);
  p_bark_mask_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bark_mask_q && cc_mask_q && (&cr_mask_q)) |-> !irq_crit_o);
endmodule

// File: tb/sim_thermal_irq_ctrl.sv
module sim_thermal_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_we = 1'b0;
  logic [1:0]  smp_ch = '0;
  logic [11:0] smp_temp = '0;
  logic        cyc_done = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_ul, irq_cr;

  int n_vec = 0;
  int n_bad = 0;

  localparam logic [7:0] CTRL = 8'h00, WDOG = 8'h01, TMO = 8'h02, WST = 8'h03;
  localparam logic [7:0] UPM = 8'h04, LOM = 8'h05, CRM = 8'h06;
  localparam logic [7:0] UPC = 8'h07, UPS = 8'h0A, LOS = 8'h0B, CRS = 8'h0C, VAL = 8'h0D;

  always #10 clk = ~clk;

  thermal_irq_ctrl u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .smp_we_i     (smp_we),
    .smp_ch_i     (smp_ch),
    .smp_temp_i   (smp_temp),
    .cycle_done_i (cyc_done),
    .reg_we_i     (reg_we),
    .reg_addr_i   (reg_addr),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .irq_uplow_o  (irq_ul),
    .irq_crit_o   (irq_cr)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic smp(input int ch, input int t);
    @(negedge clk);
    smp_we = 1'b1; smp_ch = 2'(ch); smp_temp = 12'(t);
    @(negedge clk);
    smp_we = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(UPS, d); chk("R1 up status", d, 16'h0);
    rd(LOS, d); chk("R1 low status", d, 16'h0);
    rd(CRS, d); chk("R1 crit status", d, 16'h0);
    rd(VAL, d); chk("R1 valid", d, 16'h000F);
    rd(UPM, d); chk("R1 up mask", d, 16'h000F);
    rd(CTRL, d); chk("R1 enable", d, 16'h0);
    rd(WST, d); chk("R1 wdog status", d, 16'h0);
    rd(TMO, d); chk("R1 timeout", d, 16'h0);
    chk("R1 irqs", {14'h0, irq_ul, irq_cr}, 16'h0);
  endtask

  task automatic t_valid();
    logic [15:0] d;
    smp(0, 123);
    rd(VAL, d); chk("R5 valid drop", d, 16'h000E);
    settle(5);
    rd(VAL, d); chk("R5 valid still low", d, 16'h000E);
    rd(8'h13, d); chk("R5 old temp held", d, 16'h0);
    settle(1);
    rd(VAL, d); chk("R5 valid back", d, 16'h000F);
    rd(8'h13, d); chk("R5 new temp", d, 16'd123);
  endtask

  task automatic t_thresholds();
    logic [15:0] d;
    wr(8'h14, 16'd250);
    smp(1, 249); settle(8);
    rd(UPS, d); chk("R2 below upper", d, 16'h0);
    smp(1, 250); settle(8);
    rd(UPS, d); chk("R2 equal upper", d, 16'h0002);
    rd(8'h14, d); chk("R2 thr readback", d, 16'd250);
    wr(8'h19, 16'hFF9C);  // -100
    smp(2, -100); settle(8);
    rd(LOS, d); chk("R3 equal lower", d, 16'h0004);
    rd(8'h1B, d); chk("R3 neg temp", d, 16'hFF9C);
    smp(2, -99); settle(8);
    rd(LOS, d); chk("R3 above lower", d, 16'h0);
    wr(8'h1E, 16'd900);
    smp(3, 899); settle(8);
    rd(CRS, d); chk("R4 below crit", d, 16'h0);
    smp(3, 900); settle(8);
    rd(CRS, d); chk("R4 equal crit", d, 16'h0008);
    rd(UPS, d); chk("R4 independent of upper", d, 16'h0002);
  endtask

  task automatic t_mask_enable();
    chk("R7 enable off", {15'h0, irq_ul}, 16'h0);
    wr(UPM, 16'h000D);
    wr(CTRL, 16'h0001); settle(1);
    chk("R6 unmasked upper", {15'h0, irq_ul}, 16'h1);
    wr(CTRL, 16'h0002); settle(1);
    chk("R7 lower only", {15'h0, irq_ul}, 16'h0);
    wr(CTRL, 16'h0007); wr(UPM, 16'h000F); settle(1);
    chk("R6 masked upper", {15'h0, irq_ul}, 16'h0);
    chk("R6 masked crit", {15'h0, irq_cr}, 16'h0);
    wr(CRM, 16'h0007); settle(1);
    chk("R4 crit irq", {15'h0, irq_cr}, 16'h1);
    wr(CTRL, 16'h0000); settle(1);
    chk("R7 all off", {14'h0, irq_ul, irq_cr}, 16'h0);
    wr(CRM, 16'h000F);
  endtask

  task automatic t_clear_level();
    logic [15:0] d;
    wr(UPM, 16'h000D); wr(CTRL, 16'h0001); settle(1);
    chk("R8 pre-clear irq", {15'h0, irq_ul}, 16'h1);
    wr(UPC, 16'h0002); settle(2);
    rd(UPS, d); chk("R8 cleared status", d, 16'h0);
    chk("R8 cleared irq", {15'h0, irq_ul}, 16'h0);
    settle(6);
    rd(UPS, d); chk("R8 held clear", d, 16'h0);
    wr(UPC, 16'h0000); settle(2);
    rd(UPS, d); chk("R8 status returns", d, 16'h0002);
    chk("R8 irq returns", {15'h0, irq_ul}, 16'h1);
    smp(1, 100); settle(8);
    rd(UPS, d); chk("R9 status drops", d, 16'h0);
    chk("R9 irq drops", {15'h0, irq_ul}, 16'h0);
    wr(CTRL, 16'h0000); wr(UPM, 16'h000F);
  endtask

  task automatic t_wdog();
    logic [15:0] d;
    wr(TMO, 16'd10);
    for (int i = 0; i < 10; i++) begin
      settle(3);
      pulse_done();
    end
    rd(WST, d); chk("R10 no bark while fed", d, 16'h0);
    settle(8);
    rd(WST, d); chk("R10 no bark early", d, 16'h0);
    settle(6);
    rd(WST, d); chk("R10 bark set", d[0], 16'h1);
    wr(TMO, 16'd0); settle(20);
    rd(WST, d); chk("R11 one expiry", d, 16'h0101);
    wr(CTRL, 16'h0004); settle(1);
    chk("R12 bark masked", {15'h0, irq_cr}, 16'h0);
    wr(WDOG, 16'h0008); settle(1);
    chk("R12 bark unmasked", {15'h0, irq_cr}, 16'h1);
    wr(WDOG, 16'h0009); settle(1);
    rd(WST, d); chk("R10 bark cleared", d[0], 16'h0);
    wr(WDOG, 16'h0008); settle(3);
    rd(WST, d); chk("R10 stays cleared", d[0], 16'h0);
    chk("R12 irq drops", {15'h0, irq_cr}, 16'h0);
    wr(WDOG, 16'h000A);
    wr(TMO, 16'd1); settle(300);
    wr(TMO, 16'd0); settle(2);
    rd(WST, d); chk("R11 saturated", d[15:8], 16'h00FF);
    settle(4);
    rd(WST, d); chk("R11 stays saturated", d[15:8], 16'h00FF);
    wr(WDOG, 16'h000B); wr(WDOG, 16'h000A);
  endtask

  task automatic t_cc();
    logic [15:0] d;
    pulse_done(); settle(1);
    rd(WST, d); chk("R13 masked monitor", d[1], 16'h0);
    wr(WDOG, 16'h0002);
    pulse_done(); settle(1);
    rd(WST, d); chk("R13 monitor flag", d[1], 16'h1);
    chk("R13 monitor irq", {15'h0, irq_cr}, 16'h1);
    wr(WDOG, 16'h000E); wr(WDOG, 16'h000A);
    pulse_done(); settle(1);
    rd(WST, d); chk("R13 cleared and masked", d[1], 16'h0);
    chk("R13 irq low", {15'h0, irq_cr}, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_valid();
    t_thresholds();
    t_mask_enable();
    t_clear_level();
    t_wdog();
    t_cc();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule